// File: doc/BRIEF.md
# E1 Timeslot-Zero Spare-Bit Multiframe Capture

This block sits behind an E1 receive framer that has already found frame and CRC-4 multiframe alignment. Every frame, the framer hands over the timeslot-zero byte with a strobe and the frame's position (0 to 15) inside the multiframe. The block collects the international and spare bits of that byte into eight shadow shift registers. The first bit received ends up in the most significant position of each register.

Even-numbered frames carry the alignment word, and only their international bit is collected. Odd-numbered frames carry the international bit, the remote-alarm bit and the five national spare bits, and each of these feeds its own register.

When the framer marks the end of a multiframe, the shadow contents are copied in one step into eight holding registers and a sticky status flag rises. Host software therefore has a full multiframe (2 ms) to read a consistent set. When the framer reports that multiframe alignment is lost, collection restarts from an empty state, and the holding registers and the flag are left as they were.

Top module: `e1_sa_mf_capture`

## Requirements
- R1: After reset, all eight holding outputs are zero and `mf_flag` is 0.
- R2: On a frame strobe with an even `frame_idx` (bit 0 = 0), bit 7 of `ts0_byte` is shifted into the alignment-frame international register. The bit taken first ends in bit 7 of that register after eight such frames. No other register moves.
- R3: On a frame strobe with an odd `frame_idx` (bit 0 = 1), `ts0_byte` bits are shifted MSB-first as follows: bit 7 into the non-alignment international register, bit 5 into the remote-alarm register, and bits 4, 3, 2, 1, 0 into the Sa4, Sa5, Sa6, Sa7, Sa8 registers. The alignment-frame international register does not move.
- R4: Between multiframe-end strobes, the holding outputs keep their values whatever frames arrive.
- R5: On `mf_end_stb` (without `mf_loss`), all eight holding outputs take the collected values on the next clock edge. A frame strobe in that same cycle is included in the handed-over set.
- R6: After a hand-over, collection restarts from all zeros. A multiframe cut short by an early end strobe therefore hands over only the bits seen since the previous restart, right-aligned.
- R7: `mf_flag` goes to 1 one cycle after a hand-over and stays 1 until `flag_clr` is 1. A set and a clear in the same cycle leave it at 1.
- R8: `mf_loss` empties the shadow registers and blocks any hand-over and flag set in that cycle, even if `mf_end_stb` is also 1.
- R9: While `frame_stb` is 0, `ts0_byte` and `frame_idx` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts0_byte | input | 8 | Received timeslot-zero byte |
| frame_stb | input | 1 | Byte valid for this cycle |
| frame_idx | input | 4 | Frame position within the multiframe |
| mf_end_stb | input | 1 | Multiframe ends; hand over collected set |
| mf_loss | input | 1 | Multiframe alignment lost; restart collection |
| flag_clr | input | 1 | Write-one clear of the status flag |
| si_af_q | output | 8 | International bits of alignment frames |
| si_naf_q | output | 8 | International bits of non-alignment frames |
| ra_q | output | 8 | Remote-alarm bits |
| sa4_q | output | 8 | Sa4 bits |
| sa5_q | output | 8 | Sa5 bits |
| sa6_q | output | 8 | Sa6 bits |
| sa7_q | output | 8 | Sa7 bits |
| sa8_q | output | 8 | Sa8 bits |
| mf_flag | output | 1 | Sticky new-multiframe status |

## Verification
Two cases can fall in the same cycle. The first is the capture of the last frame together with the hand-over: the bench raises the end strobe in the same cycle as the strobe for frame 15 and expects that frame's bits in the least significant position of every register. The second is a flag set together with a host clear, and the flag must stay high. A multiframe loss arriving together with an end strobe is also driven, and it must leave both the holding outputs and the flag untouched. A scoreboard model predicts every output after each cycle from the requirements.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;

   localparam int unsigned NUM_FLD = 8;

   typedef enum logic [2:0] {
      FLD_SI_AF  = 3'd0,
      FLD_SI_NAF = 3'd1,
      FLD_RA     = 3'd2,
      FLD_SA4    = 3'd3,
      FLD_SA5    = 3'd4,
      FLD_SA6    = 3'd5,
      FLD_SA7    = 3'd6,
      FLD_SA8    = 3'd7
   } fld_e;

   // bit of the timeslot-zero byte feeding each field
   function automatic int unsigned fld_src_bit(input int unsigned f);
      case (f)
         0, 1:    return 7;
         default: return 7 - f;
      endcase
   endfunction

   // alignment-word frames (even index) feed only field 0
   function automatic bit fld_from_even(input int unsigned f);
      return (f == 0);
   endfunction

endpackage

// File: rtl/e1_sa_shift.sv
module e1_sa_shift #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] nxt,
   output logic [W-1:0] q
);

   if (W < 2) begin : g_bad_w
      $error("e1_sa_shift: W must be at least 2");
   end

   always_comb begin
      nxt = q;
      if (en) nxt = {q[W-2:0], din};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= '0;
      else if (clr)  q <= '0;
      else           q <= nxt;
   end

   a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
      en && !clr |=> q[0] == $past(din));

   a_r2_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en && !clr |=> $stable(q));

   a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> q == '0);

endmodule

// File: rtl/e1_sa_hold_bank.sv
module e1_sa_hold_bank #(
   parameter int unsigned W = 8,
   parameter int unsigned N = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                flag_clr,
   input  logic [N-1:0][W-1:0] din,
   output logic [N-1:0][W-1:0] q,
   output logic                flag
);

   if (N < 1 || W < 1) begin : g_bad_dim
      $error("e1_sa_hold_bank: N and W must be non-zero");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         flag <= 1'b0;
      else if (load)      flag <= 1'b1;
      else if (flag_clr)  flag <= 1'b0;
   end

   a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q));

   a_r7_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> flag);

   a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      flag && !flag_clr |=> flag);

   a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      flag_clr && !load |=> !flag);

endmodule

// File: rtl/e1_sa_mf_capture.sv
module e1_sa_mf_capture #(
   parameter int unsigned FRAMES_PER_MF = 16,
   parameter int unsigned TS_W          = 8,
   localparam int unsigned FW           = FRAMES_PER_MF / 2,
   localparam int unsigned IDX_W        = $clog2(FRAMES_PER_MF)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  ts0_byte,
   input  logic             frame_stb,
   input  logic [IDX_W-1:0] frame_idx,
   input  logic             mf_end_stb,
   input  logic             mf_loss,
   input  logic             flag_clr,
   output logic [FW-1:0]    si_af_q,
   output logic [FW-1:0]    si_naf_q,
   output logic [FW-1:0]    ra_q,
   output logic [FW-1:0]    sa4_q,
   output logic [FW-1:0]    sa5_q,
   output logic [FW-1:0]    sa6_q,
   output logic [FW-1:0]    sa7_q,
   output logic [FW-1:0]    sa8_q,
   output logic             mf_flag
);
   import e1_sa_pkg::*;

   if (TS_W != 8) begin : g_bad_ts
      $error("e1_sa_mf_capture: TS_W must be 8");
   end
   if (FRAMES_PER_MF < 4 || (1 << IDX_W) != FRAMES_PER_MF) begin : g_bad_frames
      $error("e1_sa_mf_capture: FRAMES_PER_MF must be a power of two >= 4");
   end

   logic                      odd_frame;
   logic                      restart;
   logic                      handover;
   logic [NUM_FLD-1:0][FW-1:0] sh_q;
   logic [NUM_FLD-1:0][FW-1:0] sh_nxt;
   logic [NUM_FLD-1:0][FW-1:0] hold_q;

   assign odd_frame = frame_idx[0];
   assign restart   = mf_loss | mf_end_stb;
   assign handover  = mf_end_stb & ~mf_loss;

   for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
      localparam int unsigned SRC = fld_src_bit(f);
      logic en;
      if (fld_from_even(f)) begin : g_even
         assign en = frame_stb & ~odd_frame;
      end else begin : g_odd
         assign en = frame_stb & odd_frame;
      end

      e1_sa_shift #(.W(FW)) u_shift (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (restart),
         .en    (en),
         .din   (ts0_byte[SRC]),
         .nxt   (sh_nxt[f]),
         .q     (sh_q[f])
      );
   end

   e1_sa_hold_bank #(.W(FW), .N(NUM_FLD)) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (handover),
      .flag_clr (flag_clr),
      .din      (sh_nxt),
      .q        (hold_q),
      .flag     (mf_flag)
   );

   assign si_af_q  = hold_q[FLD_SI_AF];
   assign si_naf_q = hold_q[FLD_SI_NAF];
   assign ra_q     = hold_q[FLD_RA];
   assign sa4_q    = hold_q[FLD_SA4];
   assign sa5_q    = hold_q[FLD_SA5];
   assign sa6_q    = hold_q[FLD_SA6];
   assign sa7_q    = hold_q[FLD_SA7];
   assign sa8_q    = hold_q[FLD_SA8];

   a_r8_loss_restart: assert property (@(posedge clk) disable iff (!rst_n)
      mf_loss |=> sh_q == '0);

   a_r8_loss_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
      mf_loss && !mf_flag && !frame_stb |=> !mf_flag);

   a_r5_last_frame_in: assert property (@(posedge clk) disable iff (!rst_n)
      handover && frame_stb && odd_frame |=>
         sa8_q[0] == $past(ts0_byte[0]) && si_naf_q[0] == $past(ts0_byte[7]));

   a_r5_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      handover && frame_stb |-> frame_idx == IDX_W'(FRAMES_PER_MF - 1));

endmodule

// File: tb/tb_e1_sa_mf_capture.sv
`timescale 1ns/1ps
module tb_e1_sa_mf_capture;

   typedef struct {
      logic [63:0] hold;
      logic        flag;
      string       tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] ts0_byte = '0;
   logic       frame_stb = 1'b0;
   logic [3:0] frame_idx = '0;
   logic       mf_end_stb = 1'b0;
   logic       mf_loss = 1'b0;
   logic       flag_clr = 1'b0;
   logic [7:0] si_af_q, si_naf_q, ra_q, sa4_q, sa5_q, sa6_q, sa7_q, sa8_q;
   logic       mf_flag;

   int n_chk = 0;
   int n_bad = 0;
   exp_t sb_q[$];

   logic [7:0]  m_sh [8];
   logic [63:0] m_hold = '0;
   logic        m_flag = 1'b0;

   always #2 clk = ~clk;

   e1_sa_mf_capture dut (
      .clk(clk), .rst_n(rst_n), .ts0_byte(ts0_byte), .frame_stb(frame_stb),
      .frame_idx(frame_idx), .mf_end_stb(mf_end_stb), .mf_loss(mf_loss),
      .flag_clr(flag_clr), .si_af_q(si_af_q), .si_naf_q(si_naf_q), .ra_q(ra_q),
      .sa4_q(sa4_q), .sa5_q(sa5_q), .sa6_q(sa6_q), .sa7_q(sa7_q), .sa8_q(sa8_q),
      .mf_flag(mf_flag)
   );

   function automatic logic [63:0] outs();
      return {si_af_q, si_naf_q, ra_q, sa4_q, sa5_q, sa6_q, sa7_q, sa8_q};
   endfunction

   task automatic check(input logic [63:0] h, input logic fl, input string tag);
      n_chk++;
      if (outs() !== h || mf_flag !== fl) begin
         n_bad++;
         $display("FAIL %s: got hold=%h flag=%b, expected hold=%h flag=%b",
                  tag, outs(), mf_flag, h, fl);
      end
   endtask

   // monitor: pops the prediction for the edge just passed
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(e.hold, e.flag, e.tag);
      end
   end

   // driver: one cycle of stimulus, model update per the requirements
   task automatic step(input logic v, input int idx, input logic [7:0] b,
                       input logic e, input logic l, input logic c, input string tag);
      logic [7:0] nx [8];
      exp_t it;
      @(negedge clk);
      frame_stb = v; frame_idx = 4'(idx); ts0_byte = b;
      mf_end_stb = e; mf_loss = l; flag_clr = c;
      for (int f = 0; f < 8; f++) begin
         int  src;
         bit  en;
         src = (f < 2) ? 7 : 7 - f;
         en  = v && ((f == 0) ? (idx % 2 == 0) : (idx % 2 == 1));
         nx[f] = en ? {m_sh[f][6:0], b[src]} : m_sh[f];
      end
      if (e && !l) begin
         for (int f = 0; f < 8; f++) m_hold[63 - 8*f -: 8] = nx[f];
         m_flag = 1'b1;
      end else if (c) begin
         m_flag = 1'b0;
      end
      for (int f = 0; f < 8; f++) m_sh[f] = (e || l) ? 8'h00 : nx[f];
      it.hold = m_hold; it.flag = m_flag; it.tag = tag;
      @(posedge clk);
      it.tag = tag;
      sb_q.push_back(it);
   endtask

   // a run of frames first..last with a byte seed; optional end on last frame
   task automatic run_frames(input int first, input int last, input int seed,
                             input logic end_on_last);
      for (int i = first; i <= last; i++) begin
         logic [7:0] b;
         logic       e;
         b = 8'((i * 73 + seed * 29 + 11) ^ (seed << i % 5));
         e = end_on_last && (i == last);
         step(1'b1, i, b, e, 1'b0, 1'b0,
              e ? "R2 R3 R5 last frame with hand-over" :
                  ((i % 2 == 0) ? "R2 R4 even frame, holding steady"
                                : "R3 R4 odd frame, holding steady"));
      end
   endtask

   initial begin
      #(200000 * 4);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: got timeout, expected end of run");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      for (int f = 0; f < 8; f++) m_sh[f] = 8'h00;
      repeat (3) @(negedge clk);
      check(64'h0, 1'b0, "R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      check(64'h0, 1'b0, "R1 after reset release");

      // full multiframe, end in the same cycle as frame 15
      run_frames(0, 15, 1, 1'b1);
      // idle cycles with garbage on the byte
      for (int k = 0; k < 4; k++)
         step(1'b0, k, 8'hFF, 1'b0, 1'b0, 1'b0, "R9 no strobe, byte ignored");
      // second multiframe, end strobe on a later separate cycle, garbage in between
      run_frames(0, 7, 2, 1'b0);
      step(1'b0, 1, 8'hA5, 1'b0, 1'b0, 1'b0, "R9 no strobe mid-multiframe");
      run_frames(8, 15, 2, 1'b0);
      step(1'b0, 0, 8'h00, 1'b1, 1'b0, 1'b0, "R5 separate end strobe hand-over");
      // host clear
      step(1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b1, "R7 write-one clear");
      step(1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0, "R7 flag stays clear");
      // short multiframe: restart from zero shows right-aligned bits
      run_frames(0, 5, 3, 1'b0);
      step(1'b0, 0, 8'h00, 1'b1, 1'b0, 1'b1, "R6 R7 short hand-over with same-cycle clear");
      step(1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b0, "R7 flag sticky");
      step(1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b1, "R7 clear");
      // loss in the middle of a multiframe
      run_frames(0, 9, 4, 1'b0);
      step(1'b1, 10, 8'hFF, 1'b0, 1'b1, 1'b0, "R8 loss drops frame and shadow");
      run_frames(11, 15, 4, 1'b0);
      step(1'b0, 0, 8'h00, 1'b1, 1'b0, 1'b0, "R6 R8 hand-over after loss restart");
      step(1'b0, 0, 8'h00, 1'b0, 1'b0, 1'b1, "R7 clear");
      // loss and end together: no update, no flag
      run_frames(0, 15, 5, 1'b0);
      step(1'b0, 0, 8'h00, 1'b1, 1'b1, 1'b0, "R8 loss beats end strobe");
      step(1'b0, 0, 8'h00, 1'b1, 1'b0, 1'b0, "R8 R6 empty set after loss");
      // one more full set with a different pattern
      run_frames(0, 15, 6, 1'b1);
      repeat (2) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule